// File: doc/BRIEF.md
# Burst DMA Channel with Source-Address Reload

A single DMA channel that copies 32-bit words from a source address to a destination address, one word per transfer. Each transfer is a read beat followed by a write beat on a simple single-beat memory master port. Software programs the source address, destination address, transfer count and a control word through a small register write port, then starts the channel with a rising edge on the request input.

With source reload enabled, the channel runs in groups of four transfers. After each group the source address returns to its programmed start value, and the channel releases the bus and waits for the next rising request. The destination address and the count keep running across groups. With reload disabled, one request runs the whole count while holding the bus. When the count reaches zero, the channel clears its enable bit and sets a sticky transfer-end bit. That bit drives the interrupt when interrupts are enabled.

Top module: `dma_reload_chan`

## Requirements
- R1: Each transfer reads one word at the current source address and then writes that word to the current destination address. Each beat holds `m_valid`, `m_we` and `m_addr` steady until `m_ready` is high at a clock edge. `m_we` is 0 for a read beat and 1 for a write beat.
- R2: Register select 0 sets the source address and its reload value, select 1 sets the destination address, and select 2 sets the count. Select 3 is the control word: bit 0 enable, bits 2:1 source mode, bits 4:3 destination mode, bit 5 reload enable, bit 6 interrupt enable, bit 7 burst mode. For both mode fields, 01 adds 4 per transfer, 10 subtracts 4, and 00 or 11 keeps the address fixed.
- R3: With reload enabled, the source address returns to its programmed value after every fourth transfer. The destination address and the count carry on from where they stopped.
- R4: With reload enabled, the channel drops `bus_hold` after each group of four and performs no transfer until the next rising edge of `dreq`. With reload disabled, one rising edge runs every transfer without dropping `bus_hold`.
- R5: When the count reaches zero, the enable bit clears and `xfer_end` sets. `irq` equals `xfer_end` AND the interrupt-enable bit, so it never rises at a group boundary before the count reaches zero.
- R6: `req_clr` pulses for one cycle, together with the fall of `bus_hold`, at the end of every reload group and when the count reaches zero. It never pulses at any other time.
- R7: `cfg_err` is high while the channel is idle and enabled with reload on, if burst mode is off or the count is not a multiple of four. While `cfg_err` is high, requests start nothing.
- R8: Writing control bit 8 as 1 clears `xfer_end`. Writing it as 0 leaves `xfer_end` unchanged.
- R9: While `bus_hold` is high, register writes and further `dreq` edges have no effect.
- R10: A rising edge of `dreq` starts transfers only if the channel is enabled and the count is nonzero. A level held high starts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| dreq | input | 1 | Transfer request; rising edge starts work |
| req_clr | output | 1 | One-cycle pulse that clears the requester's flag |
| m_valid | output | 1 | Memory beat valid |
| m_we | output | 1 | 1 for a write beat, 0 for a read beat |
| m_addr | output | 32 | Beat address |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, taken when `m_ready` is high |
| m_ready | input | 1 | Beat accepted at this edge |
| bus_hold | output | 1 | Channel owns the bus |
| irq | output | 1 | Transfer-end interrupt |
| xfer_end | output | 1 | Sticky transfer-end status |
| cfg_err | output | 1 | Reload configuration error |

## Verification
The assertions assume that the memory keeps `m_rdata` valid whenever it raises `m_ready`. They also assume that software programs a count that is a multiple of four whenever reload is on and the channel is expected to run. The bench's memory model derives read data from the beat address and toggles `m_ready` at random with a fixed seed. The random cases pick counts of four, eight or twelve. A separate directed case programs a count of six with reload on, which raises the configuration error and exercises R7.

// File: rtl/dma_reload_chan.sv
module dma_reload_chan #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 24,
  parameter int GROUP = 4,
  parameter int STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq,
  output logic          req_clr,
  output logic          m_valid,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ready,
  output logic          bus_hold,
  output logic          irq,
  output logic          xfer_end,
  output logic          cfg_err
);
  localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src0, src, dst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] buf_q;
  logic [GW-1:0] grp;
  logic [1:0]    smode, dmode;
  logic          en, rld, ie, burst, te, dreq_q, clr_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] md);
    case (md)
      2'b01:   adv = a + AW'(STEP);
      2'b10:   adv = a - AW'(STEP);
      default: adv = a;
    endcase
  endfunction

  wire busy    = (st != S_IDLE);
  wire misfit  = (cnt[GW-1:0] != '0) && (GROUP > 1);
  assign cfg_err = !busy && en && rld && (!burst || misfit);
  wire start   = !busy && en && (cnt != '0) && !cfg_err && dreq && !dreq_q;
  wire last    = (cnt == CW'(1));
  wire grp_end = rld && (grp == GW'(GROUP - 1));
  wire [AW-1:0] src_nx = grp_end ? src0 : adv(src, smode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; src0 <= '0; src <= '0; dst <= '0; cnt <= '0; buf_q <= '0;
      grp <= '0; smode <= '0; dmode <= '0; en <= 1'b0; rld <= 1'b0; ie <= 1'b0;
      burst <= 1'b0; te <= 1'b0; dreq_q <= 1'b0; clr_q <= 1'b0;
    end else begin
      dreq_q <= dreq;
      clr_q  <= 1'b0;
      if (cfg_we && !busy) begin
        case (cfg_sel)
          2'd0: begin src0 <= cfg_wdata; src <= cfg_wdata; end
          2'd1: dst <= cfg_wdata;
          2'd2: cnt <= cfg_wdata[CW-1:0];
          default: begin
            en    <= cfg_wdata[0];
            smode <= cfg_wdata[2:1];
            dmode <= cfg_wdata[4:3];
            rld   <= cfg_wdata[5];
            ie    <= cfg_wdata[6];
            burst <= cfg_wdata[7];
            if (cfg_wdata[8]) te <= 1'b0;
          end
        endcase
      end
      case (st)
        S_IDLE: if (start) begin st <= S_RD; grp <= '0; end
        S_RD: if (m_ready) begin buf_q <= m_rdata; st <= S_WR; end
        S_WR: if (m_ready) begin
          cnt <= cnt - CW'(1);
          dst <= adv(dst, dmode);
          src <= src_nx;
          grp <= grp + GW'(1);
          if (last) begin
            en <= 1'b0; te <= 1'b1; clr_q <= 1'b1; st <= S_IDLE;
          end else if (grp_end) begin
            clr_q <= 1'b1; st <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign m_valid  = busy;
  assign m_we     = (st == S_WR);
  assign m_addr   = m_we ? dst : src;
  assign m_wdata  = buf_q;
  assign req_clr  = clr_q;
  assign bus_hold = busy;
  assign xfer_end = te;
  assign irq      = te && ie;
endmodule

// File: rtl/dma_reload_chan_chk.sv
module dma_reload_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_we,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic          bus_hold,
  input logic          req_clr,
  input logic          xfer_end,
  input logic          cfg_err
);
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_we)); // R1
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_we && m_ready |=> m_valid && m_we); // R1
  AST_END_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_end) |-> $past(m_valid && m_we && m_ready)); // R5
  AST_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr |-> $past(m_valid && m_we && m_ready)); // R6
  AST_RELEASE_WITH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hold) |-> req_clr); // R4
  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !bus_hold); // R7
endmodule

bind dma_reload_chan dma_reload_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_we(m_we), .m_ready(m_ready),
  .m_addr(m_addr), .bus_hold(bus_hold), .req_clr(req_clr), .xfer_end(xfer_end),
  .cfg_err(cfg_err)
);

// File: tb/dma_reload_chan_tb.sv
`timescale 1ns/1ps
module dma_reload_chan_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic dreq = 0;
  logic req_clr, m_valid, m_we, bus_hold, irq, xfer_end, cfg_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic m_ready = 0;

  always #4 clk = ~clk;

  dma_reload_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dreq(dreq), .req_clr(req_clr), .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .bus_hold(bus_hold),
    .irq(irq), .xfer_end(xfer_end), .cfg_err(cfg_err));

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction
  assign m_rdata = mem_of(m_addr);

  function automatic logic [31:0] step(input logic [31:0] a, input int md);
    if (md == 1) return a + 4;
    if (md == 2) return a - 4;
    return a;
  endfunction

  int total = 0, bad = 0, cyc = 0;
  int writes = 0, clrs = 0, falls = 0;
  logic [31:0] e_src, e_src0, e_dst;
  int e_sm, e_dm, e_grp;
  bit e_rl, prev_hold;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    m_ready = ($urandom % 3) != 0;
    if (req_clr) clrs++;
    if (prev_hold && !bus_hold) falls++;
    prev_hold = bus_hold;
    if (m_valid && m_ready) begin
      if (!m_we) begin
        chk(m_addr == e_src, "R3 read address", m_addr, e_src);
      end else begin
        chk(m_addr == e_dst, "R2 write address", m_addr, e_dst);
        chk(m_wdata == mem_of(e_src), "R1 write data", m_wdata, mem_of(e_src));
        e_src = step(e_src, e_sm);
        e_dst = step(e_dst, e_dm);
        e_grp++;
        if (e_rl && e_grp == 4) begin e_grp = 0; e_src = e_src0; end
        writes++;
      end
    end
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel[1:0]; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse();
    @(negedge clk); dreq = 1;
    repeat (2) @(negedge clk);
    dreq = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && bus_hold; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input int sm, input int dm, input bit rl, input bit ie, input bit bu);
    return 32'd1 | (sm << 1) | (dm << 3) | (rl << 5) | (ie << 6) | (bu << 7);
  endfunction

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int sm, input int dm, input bit rl);
    e_src = s; e_src0 = s; e_dst = d; e_sm = sm; e_dm = dm; e_rl = rl; e_grp = 0;
  endtask

  initial begin
    int w0, c0, f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_hold && !irq && !xfer_end && !req_clr && !cfg_err, "R5 reset state",
        {bus_hold, irq, xfer_end, req_clr, cfg_err}, 0);

    // reload on: two groups of four
    setup(32'h0400_0080, 32'h0040_0000, 1, 2, 1);
    wr(0, 32'h0400_0080); wr(1, 32'h0040_0000); wr(2, 8);
    wr(3, ctl(1, 2, 1, 1, 1));
    w0 = writes; c0 = clrs;
    pulse(); wait_idle();
    chk(writes - w0 == 4, "R4 one group per request", writes - w0, 4);
    chk(clrs - c0 == 1, "R6 clear at group end", clrs - c0, 1);
    chk(!irq && !xfer_end, "R5 no irq at group boundary", {irq, xfer_end}, 0);
    repeat (20) @(negedge clk);
    chk(writes - w0 == 4, "R4 paused without request", writes - w0, 4);
    pulse();
    wait (bus_hold);
    @(negedge clk);
    wr(2, 100);
    wait_idle();
    chk(writes - w0 == 8, "R9 count write ignored while busy", writes - w0, 8);
    chk(clrs - c0 == 2, "R6 clear at count zero", clrs - c0, 2);
    chk(xfer_end && irq, "R5 end and irq", {xfer_end, irq}, 2'b11);
    // enable cleared by end: a request now starts nothing
    w0 = writes;
    pulse(); repeat (20) @(negedge clk);
    chk(writes == w0 && !bus_hold, "R10 disabled channel ignores request", writes - w0, 0);
    wr(3, 32'h40);
    chk(xfer_end && irq, "R8 zero in bit 8 keeps status", {xfer_end, irq}, 2'b11);
    wr(3, 32'h140);
    chk(!xfer_end && !irq, "R8 one in bit 8 clears status", {xfer_end, irq}, 0);

    // reload off: one request runs the whole count holding the bus
    setup(32'h0000_1000, 32'h0000_2000, 0, 1, 0);
    wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 6);
    wr(3, ctl(0, 1, 0, 0, 1));
    w0 = writes; c0 = clrs; f0 = falls;
    @(negedge clk); dreq = 1;
    repeat (60) @(negedge clk);
    chk(writes - w0 == 6, "R10 held level starts once", writes - w0, 6);
    dreq = 0;
    wait_idle();
    chk(falls - f0 == 1, "R4 bus held throughout", falls - f0, 1);
    chk(clrs - c0 == 1, "R6 no clear mid run without reload", clrs - c0, 1);
    chk(xfer_end && !irq, "R5 end without irq enable", {xfer_end, irq}, 2'b10);
    wr(3, 32'h100);

    // configuration errors
    wr(2, 6); wr(3, ctl(1, 1, 1, 0, 1));
    @(negedge clk);
    chk(cfg_err, "R7 count not multiple of four", cfg_err, 1);
    w0 = writes;
    pulse(); repeat (20) @(negedge clk);
    chk(writes == w0, "R7 error blocks start", writes - w0, 0);
    wr(2, 8); wr(3, ctl(1, 1, 1, 0, 0));
    @(negedge clk);
    chk(cfg_err, "R7 burst off with reload", cfg_err, 1);
    wr(3, ctl(1, 1, 1, 0, 1));
    @(negedge clk);
    chk(!cfg_err, "R7 valid setting", cfg_err, 0);
    wr(3, 0);
    wr(2, 0); wr(3, ctl(1, 1, 0, 0, 1));
    w0 = writes;
    pulse(); repeat (20) @(negedge clk);
    chk(writes == w0, "R10 zero count ignored", writes - w0, 0);
    wr(3, 0);

    // random
    for (int it = 0; it < 8; it++) begin
      int sm, dm, n, ie;
      bit rl;
      logic [31:0] s, d;
      sm = $urandom % 4; dm = $urandom % 4; rl = $urandom % 2; ie = $urandom % 2;
      n = 4 * (1 + $urandom % 3);
      s = {$urandom, 2'b00}; d = {$urandom, 2'b00};
      setup(s, d, (sm == 3) ? 0 : sm, (dm == 3) ? 0 : dm, rl);
      wr(0, s); wr(1, d); wr(2, n);
      wr(3, ctl(sm, dm, rl, ie[0], 1) | 32'h100);
      w0 = writes; c0 = clrs;
      if (rl) begin
        for (int g = 0; g < n / 4; g++) begin pulse(); wait_idle(); end
      end else begin
        pulse(); wait_idle();
      end
      chk(writes - w0 == n, "R3 random transfer total", writes - w0, n);
      chk(clrs - c0 == (rl ? n / 4 : 1), "R6 random clear pulses", clrs - c0, rl ? n / 4 : 1);
      chk(xfer_end && irq == ie[0], "R5 random end status", {xfer_end, irq}, {1'b1, ie[0]});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule